// File: doc/BRIEF.md
# Palette and Pixel Format Unpacker

This block turns a stream of packed 32-bit frame-buffer words into one 24-bit RGB pixel per cycle for a display pipeline. Words arrive on a valid/ready input. Each accepted word is split into 32/bpp pixels. At 1, 2, 4 and 8 bits per pixel, each pixel is an index into a 256-entry colour table. At 16 and 32 bits per pixel, each pixel carries its colour directly. Three control bits shape the output. One selects whole-word big-endian order. One selects big-endian order of sub-byte pixels within each byte. One swaps red and blue.

The colour table holds 128 packed 32-bit words in a register window. Each word carries two 15-bit entries. A plain address/write/read-data port writes and reads the table.

The parameter `LATER_FMTS` picks the format variant:

- Base variant (`LATER_FMTS=0`): the 16-bit interpretation comes from a two-bit mux-control input.
- Later variant (`LATER_FMTS=1`): depth codes select 5551, 565 and 4-4-4 directly.

The depth, order, swap and mux settings are captured when a word is accepted. They govern every pixel of that word.

Top module: `pix_fmt_unpack`

## Requirements
- R1: The table window spans byte offsets 0x200 to 0x3FF. A write there stores the full 32-bit data in word `offset[8:2]`, and a read there returns that stored word. Reads outside the window return zero, and writes outside it change nothing.
- R2: Table entry e lives in word e>>1, in bits 14:0 when e is even and bits 30:16 when odd. Within an entry, bits 4:0 form the low field, 9:5 green and 14:10 the high field. Each 5-bit field becomes 8 bits by appending three zero bits. Bit 15 of each half has no effect.
- R3: Depth codes 0,1,2,3 give 1,2,4,8 bpp through the table. Code 5 gives 32 bpp. Codes 4,6,7 give 16 bpp. Every accepted word yields exactly 32/bpp pixels.
- R4: While a pixel is valid and not taken, `in_ready` is low and `pix_rgb` holds its value. A new word is accepted in the same cycle the last pixel of the current word is taken.
- R5: With neither order bit set, pixel k comes from bits [k*bpp +: bpp].
- R6: With only the pixel-order bit set and bpp below 8, bytes are consumed from byte 0 upward, and within a byte from the most significant pixel first. At 8 bpp and above this bit has no effect.
- R7: With the byte-order bit set, pixel k comes from the slot 32/bpp-1-k. The byte-order bit overrides the pixel-order bit.
- R8: The output is {R,G,B} with R in bits 23:16. With the swap bit clear, R takes the low field and B the high field. With it set, R takes the high field and B the low field.
- R9: At 32 bpp, bits 7:0 are the low field, 15:8 green and 23:16 the high field. Bits 31:24 are ignored.
- R10: In the base variant, 16-bit pixels are decoded by the mux-control value:
  - Value 1: 5551, with bits 4:0 low, 9:5 green, 14:10 high and bit 15 ignored.
  - Values 0 and 2: 565, with bits 4:0 low, 10:5 green (appending two zeros) and 15:11 high, honouring the swap bit.
  - Value 3: 565 decoded as if the swap bit were set.
- R11: In the later variant, 16-bit pixels are decoded by the depth code, and the mux input is ignored:
  - Code 4: 5551.
  - Code 6: 565.
  - Code 7: 4-4-4, with bits 3:0 low, 7:4 green and 11:8 high, each with four zeros appended.
- R12: Configuration changes after a word is accepted do not affect that word's pixels or pixel count.
- R13: After reset no pixel is valid and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data (combinational) |
| cfg_depth | input | 3 | Depth code |
| cfg_bgr | input | 1 | Red/blue swap bit |
| cfg_be_byte | input | 1 | Whole-word big-endian order |
| cfg_be_pix | input | 1 | Big-endian sub-byte pixel order |
| fmt_mux | input | 2 | 16-bit interpretation select (base variant) |
| in_word | input | WORD_W | Packed frame-buffer word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with valid |
| pix_rgb | output | 24 | Pixel colour {R,G,B} |
| pix_valid | output | 1 | Pixel valid |
| pix_ready | input | 1 | Pixel taken when high with valid |

## Verification
The bench builds two instances from one stimulus stream. One instance uses the default `LATER_FMTS=0` and the other uses `LATER_FMTS=1`, so every word is checked against both the mux-driven 16-bit decode and the depth-code-driven one. Both instances keep `WORD_W=32` and `INDEX_W=8`, so the whole 128-word table window is reachable and every depth code from 1 to 32 bits per pixel is exercised. Running both variants side by side shows that codes 6 and 7 decode through the mux on one instance and as 565 and 4-4-4 on the other.

// File: rtl/pfu_pkg.sv
`timescale 1ns/1ps
package pfu_pkg;

   typedef enum logic [2:0] {
      FMT_PAL  = 3'd0,
      FMT_5551 = 3'd1,
      FMT_565  = 3'd2,
      FMT_444  = 3'd3,
      FMT_888  = 3'd4
   } pix_fmt_e;

   typedef struct packed {
      logic [2:0] depth;
      logic       be_byte;
      logic       be_pix;
      logic       bgr;
      logic [1:0] mux;
   } pix_cfg_t;

   // log2 of bits per pixel for a depth code
   function automatic logic [2:0] depth_log2(input logic [2:0] depth);
      case (depth)
         3'd0:    return 3'd0;
         3'd1:    return 3'd1;
         3'd2:    return 3'd2;
         3'd3:    return 3'd3;
         3'd5:    return 3'd5;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [7:0] widen5(input logic [4:0] v);
      return {v, 3'b000};
   endfunction

   function automatic logic [7:0] widen4(input logic [3:0] v);
      return {v, 4'b0000};
   endfunction

endpackage

// File: rtl/pfu_palette.sv
`timescale 1ns/1ps
module pfu_palette #(
   parameter int          ADDR_W   = 12,
   parameter int          WORD_W   = 32,
   parameter int          INDEX_W  = 8,
   parameter logic [11:0] WIN_BASE = 12'h200
) (
   input  logic                 clk,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   input  logic [INDEX_W-1:0]   lut_idx,
   output logic [14:0]          lut_entry
);
   localparam int ENTRIES   = 1 << INDEX_W;
   localparam int WORDS     = ENTRIES / 2;
   localparam int WIDX_W    = INDEX_W - 1;
   localparam int BYTE_SH   = $clog2(WORD_W / 8);
   localparam int WIN_BYTES = WORDS * (WORD_W / 8);
   localparam int HALF      = WORD_W / 2;
   localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
   localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(int'(WIN_BASE) + WIN_BYTES);

   if (int'(WIN_BASE) % WIN_BYTES != 0) begin : g_bad_base
      $error("table window base must be aligned to the window size");
   end

   logic [WORD_W-1:0] mem_q [WORDS];
   logic              in_win;
   logic [WIDX_W-1:0] widx;
   logic [WORD_W-1:0] sel_word;

   assign in_win = ({1'b0, reg_addr} >= WIN_LO) && ({1'b0, reg_addr} < WIN_HI);
   assign widx   = reg_addr[BYTE_SH +: WIDX_W];

   always_ff @(posedge clk) begin
      if (reg_wr && in_win) begin
         mem_q[widx] <= reg_wdata;
      end
   end

   assign reg_rdata = in_win ? mem_q[widx] : '0;

   assign sel_word  = mem_q[lut_idx[INDEX_W-1:1]];
   assign lut_entry = lut_idx[0] ? sel_word[HALF +: 15] : sel_word[14:0];

   logic unused_intensity;
   assign unused_intensity = ^{sel_word[HALF-1], sel_word[WORD_W-1]};

endmodule

// File: rtl/pfu_slicer.sv
`timescale 1ns/1ps
module pfu_slicer
   import pfu_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   output logic              in_ready,
   input  pix_cfg_t          cfg_in,
   output logic              pix_valid,
   input  logic              pix_ready,
   output logic [WORD_W-1:0] code,
   output pix_cfg_t          cfg_q
);
   localparam int CNT_W = $clog2(WORD_W);

   logic [WORD_W-1:0] word_q;
   logic              busy_q;
   logic [CNT_W-1:0]  idx_q;
   logic [2:0]        lg;
   logic [CNT_W-1:0]  last_idx;
   logic              at_last;
   logic              load;
   logic              take;
   logic [CNT_W-1:0]  slot;
   logic [CNT_W-1:0]  shift;
   logic [WORD_W-1:0] field_mask;

   assign lg       = depth_log2(cfg_q.depth);
   assign last_idx = CNT_W'((WORD_W >> lg) - 1);
   assign at_last  = (idx_q == last_idx);
   assign take     = busy_q && pix_ready;
   assign in_ready = !busy_q || (pix_ready && at_last);
   assign load     = in_valid && in_ready;
   assign pix_valid = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         word_q <= '0;
         cfg_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         word_q <= in_word;
         cfg_q  <= cfg_in;
      end else if (take) begin
         if (at_last) begin
            busy_q <= 1'b0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // slot of the current pixel counted from the least significant end
   always_comb begin
      slot = idx_q;
      if (cfg_q.be_byte) begin
         slot = idx_q ^ last_idx;
      end else if (cfg_q.be_pix && (lg < 3'd3)) begin
         slot = idx_q ^ CNT_W'((8 >> lg) - 1);
      end
   end

   assign shift      = slot << lg;
   assign field_mask = ~({WORD_W{1'b1}} << (32'd1 << lg));
   assign code       = (word_q >> shift) & field_mask;

endmodule

// File: rtl/pfu_colour.sv
`timescale 1ns/1ps
module pfu_colour
   import pfu_pkg::*;
#(
   parameter bit LATER_FMTS = 1'b0
) (
   input  logic [23:0] code,
   input  pix_cfg_t    cfg,
   input  logic [14:0] pal_entry,
   output logic [23:0] rgb
);
   pix_fmt_e   fmt;
   logic       swap_rb;
   logic [7:0] lo_f;
   logic [7:0] gr_f;
   logic [7:0] hi_f;

   if (LATER_FMTS) begin : g_later
      always_comb begin
         swap_rb = cfg.bgr;
         case (cfg.depth)
            3'd0, 3'd1, 3'd2, 3'd3: fmt = FMT_PAL;
            3'd5:                   fmt = FMT_888;
            3'd6:                   fmt = FMT_565;
            3'd7:                   fmt = FMT_444;
            default:                fmt = FMT_5551;
         endcase
      end
   end else begin : g_base
      always_comb begin
         swap_rb = cfg.bgr;
         if (cfg.depth < 3'd4) begin
            fmt = FMT_PAL;
         end else if (cfg.depth == 3'd5) begin
            fmt = FMT_888;
         end else begin
            case (cfg.mux)
               2'd1: fmt = FMT_5551;
               2'd3: begin
                  fmt     = FMT_565;
                  swap_rb = 1'b1;
               end
               default: fmt = FMT_565;
            endcase
         end
      end
   end

   always_comb begin
      case (fmt)
         FMT_PAL: begin
            lo_f = widen5(pal_entry[4:0]);
            gr_f = widen5(pal_entry[9:5]);
            hi_f = widen5(pal_entry[14:10]);
         end
         FMT_5551: begin
            lo_f = widen5(code[4:0]);
            gr_f = widen5(code[9:5]);
            hi_f = widen5(code[14:10]);
         end
         FMT_565: begin
            lo_f = widen5(code[4:0]);
            gr_f = {code[10:5], 2'b00};
            hi_f = widen5(code[15:11]);
         end
         FMT_444: begin
            lo_f = widen4(code[3:0]);
            gr_f = widen4(code[7:4]);
            hi_f = widen4(code[11:8]);
         end
         default: begin
            lo_f = code[7:0];
            gr_f = code[15:8];
            hi_f = code[23:16];
         end
      endcase
      rgb = swap_rb ? {hi_f, gr_f, lo_f} : {lo_f, gr_f, hi_f};
   end

endmodule

// File: rtl/pix_fmt_unpack.sv
`timescale 1ns/1ps
module pix_fmt_unpack
   import pfu_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          WORD_W     = 32,
   parameter int          INDEX_W    = 8,
   parameter logic [11:0] PAL_BASE   = 12'h200,
   parameter bit          LATER_FMTS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic [2:0]        cfg_depth,
   input  logic              cfg_bgr,
   input  logic              cfg_be_byte,
   input  logic              cfg_be_pix,
   input  logic [1:0]        fmt_mux,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [23:0]       pix_rgb,
   output logic              pix_valid,
   input  logic              pix_ready
);
   if (WORD_W != 32) begin : g_bad_word
      $error("word width must be 32");
   end
   if (INDEX_W != 8) begin : g_bad_index
      $error("table index width must be 8");
   end

   pix_cfg_t          cfg_in;
   pix_cfg_t          cfg_word;
   logic [WORD_W-1:0] code_w;
   logic [14:0]       entry_w;

   assign cfg_in = '{depth: cfg_depth, be_byte: cfg_be_byte, be_pix: cfg_be_pix,
                     bgr: cfg_bgr, mux: fmt_mux};

   pfu_palette #(
      .ADDR_W   (ADDR_W),
      .WORD_W   (WORD_W),
      .INDEX_W  (INDEX_W),
      .WIN_BASE (PAL_BASE)
   ) pal_i (
      .clk       (clk),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .lut_idx   (code_w[INDEX_W-1:0]),
      .lut_entry (entry_w)
   );

   pfu_slicer #(
      .WORD_W (WORD_W)
   ) slc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_word   (in_word),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .cfg_in    (cfg_in),
      .pix_valid (pix_valid),
      .pix_ready (pix_ready),
      .code      (code_w),
      .cfg_q     (cfg_word)
   );

   pfu_colour #(
      .LATER_FMTS (LATER_FMTS)
   ) col_i (
      .code      (code_w[23:0]),
      .cfg       (cfg_word),
      .pal_entry (entry_w),
      .rgb       (pix_rgb)
   );

   logic unused_code_top;
   assign unused_code_top = ^code_w[WORD_W-1:24];

endmodule

// File: rtl/pfu_chk.sv
`timescale 1ns/1ps
module pfu_chk
   import pfu_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          WORD_W   = 32,
   parameter logic [11:0] PAL_BASE = 12'h200
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [WORD_W-1:0] reg_wdata,
   input logic [WORD_W-1:0] reg_rdata,
   input logic [2:0]        cfg_depth,
   input logic              in_valid,
   input logic              in_ready,
   input logic [23:0]       pix_rgb,
   input logic              pix_valid,
   input logic              pix_ready
);
   localparam int LO = int'(PAL_BASE);
   localparam int HI = int'(PAL_BASE) + 128 * (WORD_W / 8);

   logic       win;
   logic       load;
   logic       take;
   logic [5:0] exp_q;
   logic [5:0] taken_q;
   logic       seen_q;

   assign win  = (int'(reg_addr) >= LO) && (int'(reg_addr) < HI);
   assign load = in_valid && in_ready;
   assign take = pix_valid && pix_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_q   <= '0;
         taken_q <= '0;
         seen_q  <= 1'b0;
      end else if (load) begin
         exp_q   <= 6'(WORD_W >> depth_log2(cfg_depth));
         taken_q <= '0;
         seen_q  <= 1'b1;
      end else if (take) begin
         taken_q <= taken_q + 1'b1;
      end
   end

   // R1
   win_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win |-> reg_rdata == '0);

   // R1
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_wr && win) && reg_addr == $past(reg_addr)) |-> reg_rdata == $past(reg_wdata));

   // R4
   no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready) |-> !in_ready);

   // R4
   hold_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_ready && !reg_wr) |=> (pix_valid && $stable(pix_rgb)));

   // R3
   pix_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && seen_q) |-> (taken_q + 6'(take)) == exp_q);

   // R13
   reset_idle_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!pix_valid && in_ready));

endmodule

bind pix_fmt_unpack pfu_chk #(
   .ADDR_W   (ADDR_W),
   .WORD_W   (WORD_W),
   .PAL_BASE (PAL_BASE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .cfg_depth (cfg_depth),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .pix_rgb   (pix_rgb),
   .pix_valid (pix_valid),
   .pix_ready (pix_ready)
);

// File: tb/pix_fmt_unpack_tb_top.sv
`timescale 1ns/1ps
module pix_fmt_unpack_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  cfg_depth = '0;
   logic        cfg_bgr = 1'b0;
   logic        cfg_be_byte = 1'b0;
   logic        cfg_be_pix = 1'b0;
   logic [1:0]  fmt_mux = '0;
   logic [31:0] in_word = '0;
   logic        in_valid = 1'b0;
   logic        pix_ready = 1'b0;

   logic [31:0] rdata_b, rdata_l;
   logic        rdy_b, rdy_l, vld_b, vld_l;
   logic [23:0] rgb_b, rgb_l;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] pal_m [128];

   always #2.5 clk = ~clk;

   pix_fmt_unpack #(.LATER_FMTS(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .cfg_depth(cfg_depth),
      .cfg_bgr(cfg_bgr), .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix),
      .fmt_mux(fmt_mux), .in_word(in_word), .in_valid(in_valid), .in_ready(rdy_b),
      .pix_rgb(rgb_b), .pix_valid(vld_b), .pix_ready(pix_ready));

   pix_fmt_unpack #(.LATER_FMTS(1'b1)) dut_later_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_l), .cfg_depth(cfg_depth),
      .cfg_bgr(cfg_bgr), .cfg_be_byte(cfg_be_byte), .cfg_be_pix(cfg_be_pix),
      .fmt_mux(fmt_mux), .in_word(in_word), .in_valid(in_valid), .in_ready(rdy_l),
      .pix_rgb(rgb_l), .pix_valid(vld_l), .pix_ready(pix_ready));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic int bpp_of(input logic [2:0] d);
      case (d)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return 4;
         3'd3: return 8;
         3'd5: return 32;
         default: return 16;
      endcase
   endfunction

   // pixel bits from the requirement wording (R5, R6, R7)
   function automatic logic [31:0] ref_code(input logic [31:0] w, input int k,
         input logic [2:0] d, input logic bebo, input logic bepo);
      int bpp = bpp_of(d);
      int n = 32 / bpp;
      int pos;
      logic [31:0] v = '0;
      if (bebo) pos = (n - 1 - k) * bpp;
      else if (bepo && bpp < 8) begin
         int per = 8 / bpp;
         pos = (k / per) * 8 + (per - 1 - (k % per)) * bpp;
      end else pos = k * bpp;
      for (int b = 0; b < bpp; b++) v[b] = w[pos + b];
      return v;
   endfunction

   // colour from the requirement wording (R2, R8-R11)
   function automatic logic [23:0] ref_rgb(input bit later, input logic [31:0] c,
         input logic [2:0] d, input logic bgr, input logic [1:0] mux);
      logic [7:0] lo, gr, hi;
      logic [31:0] e;
      logic sw = bgr;
      int kind; // 0 table, 1 5551, 2 565, 3 444, 4 888
      if (d <= 3) kind = 0;
      else if (d == 5) kind = 4;
      else if (later) kind = (d == 4) ? 1 : (d == 6) ? 2 : 3;
      else if (mux == 1) kind = 1;
      else begin
         kind = 2;
         if (mux == 3) sw = 1'b1;
      end
      e = pal_m[c[7:1]];
      if (c[0]) e = e >> 16;
      case (kind)
         0: begin lo = {e[4:0], 3'd0}; gr = {e[9:5], 3'd0}; hi = {e[14:10], 3'd0}; end
         1: begin lo = {c[4:0], 3'd0}; gr = {c[9:5], 3'd0}; hi = {c[14:10], 3'd0}; end
         2: begin lo = {c[4:0], 3'd0}; gr = {c[10:5], 2'd0}; hi = {c[15:11], 3'd0}; end
         3: begin lo = {c[3:0], 4'd0}; gr = {c[7:4], 4'd0}; hi = {c[11:8], 4'd0}; end
         default: begin lo = c[7:0]; gr = c[15:8]; hi = c[23:16]; end
      endcase
      return sw ? {hi, gr, lo} : {lo, gr, hi};
   endfunction

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_check(input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b0;
      #1;
      check("R1 table read base", rdata_b, exp);
      check("R1 table read later", rdata_l, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R13 valid after reset", {31'd0, vld_b}, 32'd0);
      check("R13 ready after reset", {31'd0, rdy_b}, 32'd1);
      check("R13 later valid after reset", {31'd0, vld_l}, 32'd0);
   endtask

   task automatic t_table();
      for (int n = 0; n < 128; n++) begin
         pal_m[n] = 32'h9E37_79B9 * (n + 3);
         reg_write(12'h200 + 12'(n * 4), pal_m[n]);
      end
      for (int n = 0; n < 128; n++) reg_check(12'h200 + 12'(n * 4), pal_m[n]);
      reg_write(12'h1FC, 32'hDEAD_BEEF);
      reg_write(12'h400, 32'hDEAD_BEEF);
      reg_check(12'h1FC, 32'd0);
      reg_check(12'h400, 32'd0);
      reg_check(12'h200, pal_m[0]);
      reg_check(12'h3FC, pal_m[127]);
   endtask

   task automatic t_stream(input string req, input logic [2:0] d, input logic bebo,
         input logic bepo, input logic bgr, input logic [1:0] mux,
         input logic [31:0] w, input bit stall, input bit alter);
      int n = 32 / bpp_of(d);
      logic [23:0] eb, el;
      @(negedge clk);
      cfg_depth = d; cfg_be_byte = bebo; cfg_be_pix = bepo; cfg_bgr = bgr; fmt_mux = mux;
      in_word = w; in_valid = 1'b1; pix_ready = 1'b0;
      #1;
      check({req, " ready when idle"}, {31'd0, rdy_b}, 32'd1);
      @(negedge clk);
      in_valid = 1'b0;
      if (alter) begin
         // R12: disturb every setting after acceptance
         cfg_depth = ~d; cfg_be_byte = ~bebo; cfg_be_pix = ~bepo; cfg_bgr = ~bgr; fmt_mux = ~mux;
      end
      for (int k = 0; k < n; k++) begin
         eb = ref_rgb(1'b0, ref_code(w, k, d, bebo, bepo), d, bgr, mux);
         el = ref_rgb(1'b1, ref_code(w, k, d, bebo, bepo), d, bgr, mux);
         if (stall) begin
            pix_ready = 1'b0;
            #1;
            check({req, " R4 stalled ready"}, {31'd0, rdy_b}, 32'd0);
            check({req, " R4 stalled pixel"}, {8'd0, rgb_b}, {8'd0, eb});
            @(negedge clk);
         end
         pix_ready = 1'b1;
         #1;
         check({req, " valid"}, {31'd0, vld_b}, 32'd1);
         check({req, " base pixel"}, {8'd0, rgb_b}, {8'd0, eb});
         check({req, " later pixel"}, {8'd0, rgb_l}, {8'd0, el});
         check({req, " R3 ready at last"}, {31'd0, rdy_b}, {31'd0, k == n - 1});
         @(negedge clk);
      end
      pix_ready = 1'b0;
      #1;
      check({req, " R3 done after count"}, {31'd0, vld_b}, 32'd0);
   endtask

   task automatic t_overlap();
      logic [31:0] wa = 32'h5511_2233;
      logic [31:0] wb = 32'hAA44_5566;
      @(negedge clk);
      cfg_depth = 3'd5; cfg_be_byte = 0; cfg_be_pix = 0; cfg_bgr = 0; fmt_mux = 0;
      in_word = wa; in_valid = 1'b1; pix_ready = 1'b0;
      @(negedge clk);
      in_word = wb; pix_ready = 1'b1;
      #1;
      check("R4 accept with last take", {31'd0, rdy_b}, 32'd1);
      check("R4 first word pixel", {8'd0, rgb_b}, {8'd0, 24'h332211});
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check("R4 second word follows", {8'd0, rgb_b}, {8'd0, 24'h665544});
      check("R4 second word valid", {31'd0, vld_b}, 32'd1);
      @(negedge clk);
      pix_ready = 1'b0;
      #1;
      check("R4 drained", {31'd0, vld_b}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      t_reset();
      t_table();
      t_stream("R5 R2 R8 1bpp little", 3'd0, 0, 0, 0, 2'd0, 32'hA5C3_0F96, 0, 0);
      t_stream("R6 R2 2bpp pixel order", 3'd1, 0, 1, 1, 2'd0, 32'h1B6C_E4D2, 0, 0);
      t_stream("R6 4bpp pixel order", 3'd2, 0, 1, 0, 2'd0, 32'h7E29_C4B1, 0, 0);
      t_stream("R7 4bpp byte order", 3'd2, 1, 0, 0, 2'd0, 32'h0123_89AB, 1, 0);
      t_stream("R7 8bpp byte over pixel", 3'd3, 1, 1, 1, 2'd0, 32'hF0E1_D2C3, 0, 0);
      t_stream("R6 8bpp no effect", 3'd3, 0, 1, 0, 2'd0, 32'h4C3B_2A19, 0, 0);
      t_stream("R10 R11 16bpp mux0", 3'd4, 0, 0, 0, 2'd0, 32'h8421_7BDE, 0, 0);
      t_stream("R10 R11 16bpp mux1", 3'd4, 0, 0, 1, 2'd1, 32'hFFFF_0001, 0, 0);
      t_stream("R10 16bpp mux2 swap", 3'd4, 0, 0, 1, 2'd2, 32'hF81F_07E0, 0, 0);
      t_stream("R10 16bpp mux3 forced", 3'd4, 0, 0, 0, 2'd3, 32'h001F_F800, 0, 0);
      t_stream("R11 code6 565", 3'd6, 0, 0, 0, 2'd1, 32'hC618_39E7, 0, 0);
      t_stream("R11 code7 444", 3'd7, 1, 0, 1, 2'd3, 32'hABCD_1357, 0, 0);
      t_stream("R9 R8 32bpp", 3'd5, 0, 0, 0, 2'd0, 32'hFF12_3456, 0, 0);
      t_stream("R9 R8 32bpp swap", 3'd5, 1, 0, 1, 2'd0, 32'h7FAB_CDEF, 0, 0);
      t_stream("R12 settings latched", 3'd3, 0, 0, 0, 2'd0, 32'h0F1E_2D3C, 0, 1);
      t_stream("R12 latched sub-byte", 3'd0, 0, 1, 1, 2'd2, 32'h8001_FF7E, 1, 1);
      t_overlap();
      repeat (2) @(negedge clk);
      report();
   end

endmodule